// File: doc/BRIEF.md
# Flash Readout Protection Gate

This block sits in front of an on-chip flash controller. It holds one byte of protection configuration. On every flash access it decides whether the access is granted or denied. The byte carries three two-bit fields: a first-level enable pair, a second-level enable pair and a release pair. Together they give an effective protection level of off, level 1 or level 2.

Accesses in the parallel programming mode are refused while any protection level is active. Serial and CPU rewrite accesses are always passed on, because identity checks for those modes are done elsewhere. A readout flagged as coming from a factory tester is refused only at level 2.

The release pair can switch protection off completely. While protection is active, writes to the release pair in parallel mode are dropped, so protection can only be cleared from the serial or CPU rewrite modes.

Top module: `flash_guard_top`

## Requirements
- R1: After reset the register reads 8'hFF, `level_o` is 0 and `rsp_valid_o` is low.
- R2: The first-level pair is bits [7:6] and the second-level pair is bits [3:2]. A pair requests its level when it holds any value other than 2'b11.
- R3: When the release pair (bits [5:4]) is 2'b00, the level is 0, whatever the other pairs hold.
- R4: When both pairs request protection and the release pair is not 2'b00, the level is 2.
- R5: `level_o` is coded 0 for off, 1 for level 1 and 2 for level 2. The value 3 never appears.
- R6: For a non-tester request in parallel mode (`mode_i` 2'b00, with 2'b11 treated the same way), any request kind is denied when the level is not 0 and granted when it is 0. The kinds are read 2'b00, program 2'b01 and erase 2'b10.
- R7: A request with `tester_i` high and kind read is denied at level 2 and granted at levels 0 and 1, in any mode. A tester flag on any other kind is ignored.
- R8: Non-tester requests in serial mode (2'b01) or CPU rewrite mode (2'b10) are always granted.
- R9: Each request strobe gives exactly one `rsp_valid_o` pulse, one cycle long, in the cycle after the strobe. `rsp_grant_o` carries the decision made from the register value at the strobe.
- R10: In parallel mode with a level other than 0, a register write leaves the release pair unchanged. The other fields still take the written value.
- R11: Writes in serial or CPU rewrite mode, or in parallel mode while the level is 0, store all writable bits. The new value is visible from the clock edge that samples the write strobe.
- R12: Bits [1:0] always read back as 2'b11, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Access mode: 0 parallel, 1 serial, 2 CPU rewrite, 3 treated as parallel |
| req_valid_i | input | 1 | Access request strobe |
| req_kind_i | input | 2 | Request kind: 0 read, 1 program, 2 erase |
| tester_i | input | 1 | Request comes from a factory tester |
| cfg_we_i | input | 1 | Protection register write strobe |
| cfg_wdata_i | input | 8 | Protection register write data |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_grant_o | output | 1 | 1 when the access is granted, 0 when it is denied |
| level_o | output | 2 | Decoded protection level |
| cfg_rdata_o | output | 8 | Protection register readback |

## Verification
The assertions assume that `mode_i`, `req_kind_i` and `tester_i` are stable and meaningful in any cycle where `req_valid_i` is high. They also assume that the write strobe and a request may share a cycle, with the request judged against the old register value. The stimulus changes inputs only on the falling edge and holds them for a full cycle. Configuration values in the vector table are loaded through serial-mode writes, so the lock never interferes. The lock itself is exercised only in directed tests that switch to parallel mode on purpose.

// File: rtl/fguard_pkg.sv
package fguard_pkg;
    localparam int CFG_W   = 8;
    localparam int L1_LSB  = 6;
    localparam int REL_LSB = 4;
    localparam int L2_LSB  = 2;
    localparam int PAIR_W  = 2;
    localparam logic [CFG_W-1:0] CFG_RESET = '1;

    typedef enum logic [1:0] {MODE_PAR = 2'd0, MODE_SER = 2'd1, MODE_CPU = 2'd2, MODE_RSV = 2'd3} acc_mode_e;
    typedef enum logic [1:0] {REQ_READ = 2'd0, REQ_PROG = 2'd1, REQ_ERASE = 2'd2, REQ_RSV = 2'd3} req_kind_e;
    typedef enum logic [1:0] {LVL_OFF = 2'd0, LVL_ONE = 2'd1, LVL_TWO = 2'd2, LVL_BAD = 2'd3} prot_lvl_e;

    function automatic logic is_parallel(acc_mode_e m);
        return (m == MODE_PAR) || (m == MODE_RSV);
    endfunction
endpackage

// File: rtl/fguard_cfg_reg.sv
module fguard_cfg_reg
    import fguard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  acc_mode_e        mode,
    input  logic             prot_active,
    output logic [CFG_W-1:0] cfg
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       lock_release;

    always_comb begin
        st_d = st_q;
        lock_release = is_parallel(mode) && prot_active;
        if (we) begin
            st_d.cfg = wdata;
            st_d.cfg[L2_LSB-1:0] = '1;
            if (lock_release) begin
                st_d.cfg[REL_LSB +: PAIR_W] = st_q.cfg[REL_LSB +: PAIR_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cfg: CFG_RESET};
        else        st_q <= st_d;
    end

    assign cfg = st_q.cfg;

    p_reserved_ones_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[L2_LSB-1:0] == '1);

    p_release_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && is_parallel(mode) && prot_active) |=> $stable(cfg[REL_LSB +: PAIR_W]));

    p_free_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !is_parallel(mode)) |=> (cfg[CFG_W-1:L2_LSB] == $past(wdata[CFG_W-1:L2_LSB])));
endmodule

// File: rtl/fguard_level_dec.sv
module fguard_level_dec
    import fguard_pkg::*;
(
    input  logic [PAIR_W-1:0] l1_pair,
    input  logic [PAIR_W-1:0] rel_pair,
    input  logic [PAIR_W-1:0] l2_pair,
    output prot_lvl_e         level
);
    logic l1_req, l2_req, released;

    always_comb begin
        l1_req   = (l1_pair != '1);
        l2_req   = (l2_pair != '1);
        released = (rel_pair == '0);
        if (released)    level = LVL_OFF;
        else if (l2_req) level = LVL_TWO;
        else if (l1_req) level = LVL_ONE;
        else             level = LVL_OFF;
    end
endmodule

// File: rtl/fguard_arbiter.sv
module fguard_arbiter
    import fguard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  req_kind_e kind,
    input  acc_mode_e mode,
    input  logic      tester,
    input  prot_lvl_e level,
    output logic      rsp_valid,
    output logic      rsp_grant
);
    typedef struct packed {
        logic valid;
        logic grant;
    } rsp_state_t;

    rsp_state_t st_d, st_q;
    logic       allow;

    always_comb begin
        if (tester && (kind == REQ_READ)) allow = (level != LVL_TWO);
        else if (is_parallel(mode))       allow = (level == LVL_OFF);
        else                              allow = 1'b1;
        st_d.valid = req_valid;
        st_d.grant = req_valid ? allow : st_q.grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign rsp_grant = st_q.grant;

    p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_spurious_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_side_mode_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !tester && !is_parallel(mode)) |=> rsp_grant);
    p_tester_l2_deny_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && tester && kind == REQ_READ && level == LVL_TWO) |=> !rsp_grant);
    p_par_protected_deny_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !tester && is_parallel(mode) && level != LVL_OFF) |=> !rsp_grant);
endmodule

// File: rtl/flash_guard_top.sv
module flash_guard_top
    import fguard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             req_valid_i,
    input  logic [1:0]       req_kind_i,
    input  logic             tester_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic             rsp_valid_o,
    output logic             rsp_grant_o,
    output logic [1:0]       level_o,
    output logic [CFG_W-1:0] cfg_rdata_o
);
    acc_mode_e        mode;
    req_kind_e        kind;
    prot_lvl_e        level;
    logic [CFG_W-1:0] cfg;

    assign mode = acc_mode_e'(mode_i);
    assign kind = req_kind_e'(req_kind_i);

    fguard_cfg_reg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we_i),
        .wdata       (cfg_wdata_i),
        .mode        (mode),
        .prot_active (level != LVL_OFF),
        .cfg         (cfg)
    );

    fguard_level_dec u_dec (
        .l1_pair  (cfg[L1_LSB +: PAIR_W]),
        .rel_pair (cfg[REL_LSB +: PAIR_W]),
        .l2_pair  (cfg[L2_LSB +: PAIR_W]),
        .level    (level)
    );

    fguard_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid_i),
        .kind      (kind),
        .mode      (mode),
        .tester    (tester_i),
        .level     (level),
        .rsp_valid (rsp_valid_o),
        .rsp_grant (rsp_grant_o)
    );

    assign level_o     = level;
    assign cfg_rdata_o = cfg;

    p_released_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata_o[REL_LSB +: PAIR_W] == '0) |-> (level_o == 2'd0));
    p_level_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        level_o != 2'd3);
    p_both_pairs_l2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata_o[L1_LSB +: PAIR_W] != '1 && cfg_rdata_o[L2_LSB +: PAIR_W] != '1
         && cfg_rdata_o[REL_LSB +: PAIR_W] != '0) |-> (level_o == 2'd2));
endmodule

// File: tb/flash_guard_top_test.sv
`timescale 1ns/100ps
module flash_guard_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'd1;
    logic       req_valid_i = 1'b0;
    logic [1:0] req_kind_i = 2'd0;
    logic       tester_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [7:0] cfg_wdata_i = 8'h00;
    logic       rsp_valid_o, rsp_grant_o;
    logic [1:0] level_o;
    logic [7:0] cfg_rdata_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    flash_guard_top uut (.*);

    // cfg, mode, kind, tester, grant, level
    localparam logic [15:0] VEC [14] = '{
        {8'hFF, 2'd0, 2'd0, 1'b0, 1'b1, 2'd0},  // R2 unprotected
        {8'h7F, 2'd0, 2'd0, 1'b0, 1'b0, 2'd1},  // R2 R6 level 1
        {8'hBF, 2'd0, 2'd1, 1'b0, 1'b0, 2'd1},  // R2 R6 program
        {8'hF3, 2'd0, 2'd2, 1'b0, 1'b0, 2'd2},  // R2 R6 erase level 2
        {8'h33, 2'd0, 2'd0, 1'b0, 1'b0, 2'd2},  // R4 both
        {8'h03, 2'd0, 2'd0, 1'b0, 1'b1, 2'd0},  // R3 released
        {8'h4F, 2'd0, 2'd1, 1'b0, 1'b1, 2'd0},  // R3 released with l1
        {8'h7F, 2'd1, 2'd0, 1'b0, 1'b1, 2'd1},  // R8 serial
        {8'hF3, 2'd2, 2'd2, 1'b0, 1'b1, 2'd2},  // R8 cpu rewrite
        {8'h7F, 2'd0, 2'd0, 1'b1, 1'b1, 2'd1},  // R7 tester l1
        {8'hF3, 2'd0, 2'd0, 1'b1, 1'b0, 2'd2},  // R7 tester l2
        {8'hF3, 2'd1, 2'd0, 1'b1, 1'b0, 2'd2},  // R7 tester l2 serial
        {8'h7F, 2'd3, 2'd0, 1'b0, 1'b0, 2'd1},  // R6 mode 3
        {8'h5F, 2'd0, 2'd2, 1'b1, 1'b0, 2'd1}   // R7 tester on erase ignored
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] v, input logic [1:0] m);
        cfg_we_i = 1'b1; cfg_wdata_i = v; mode_i = m;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cfg_rdata_o == 8'hFF, "R1 cfg", cfg_rdata_o, 8'hFF);
        check(level_o == 2'd0, "R1 level", level_o, 0);
        check(rsp_valid_o == 1'b0, "R1 valid", rsp_valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VEC[i]) begin
            cfg_write(VEC[i][15:8], 2'd1);
            check(level_o == VEC[i][1:0], "R2/R3/R4/R5 level", level_o, VEC[i][1:0]);
            check(cfg_rdata_o == (VEC[i][15:8] | 8'h03), "R11 readback", cfg_rdata_o, VEC[i][15:8] | 8'h03);
            mode_i = VEC[i][7:6]; req_kind_i = VEC[i][5:4]; tester_i = VEC[i][3];
            req_valid_i = 1'b1;
            @(negedge clk);
            req_valid_i = 1'b0; tester_i = 1'b0;
            check(rsp_valid_o == 1'b1, "R9 valid", rsp_valid_o, 1);
            check(rsp_grant_o == VEC[i][2], "R6/R7/R8 grant", rsp_grant_o, VEC[i][2]);
        end

        // R9: pulse lasts one cycle only
        @(negedge clk);
        check(rsp_valid_o == 1'b0, "R9 single pulse", rsp_valid_o, 0);

        // R10: release pair locked in parallel mode while protected
        cfg_write(8'h7F, 2'd1);
        cfg_write(8'h4C, 2'd0);
        check(cfg_rdata_o == 8'h7F, "R10 lock", cfg_rdata_o, 8'h7F);
        check(level_o == 2'd1, "R10 level kept", level_o, 1);
        // R10: other fields still written under lock
        cfg_write(8'hC3, 2'd0);
        check(cfg_rdata_o == 8'hF3, "R10 other fields", cfg_rdata_o, 8'hF3);

        // R11: serial write clears release, timing at edge
        cfg_we_i = 1'b1; cfg_wdata_i = 8'h4C; mode_i = 2'd1;
        #1;
        check(cfg_rdata_o == 8'hF3, "R11 before edge", cfg_rdata_o, 8'hF3);
        @(negedge clk);
        cfg_we_i = 1'b0;
        check(cfg_rdata_o == 8'h4F, "R11 serial write", cfg_rdata_o, 8'h4F);
        check(level_o == 2'd0, "R3 released", level_o, 0);
        // R11: parallel write accepted while unprotected
        cfg_write(8'hCF, 2'd0);
        check(cfg_rdata_o == 8'hCF, "R11 parallel unprotected", cfg_rdata_o, 8'hCF);
        cfg_write(8'h33, 2'd0);
        check(cfg_rdata_o == 8'h33, "R11 parallel set", cfg_rdata_o, 8'h33);
        check(level_o == 2'd2, "R4 level", level_o, 2);
        // R11: cpu rewrite mode releases
        cfg_write(8'h0F, 2'd2);
        check(cfg_rdata_o == 8'h0F, "R11 cpu write", cfg_rdata_o, 8'h0F);

        // R12: reserved bits read as ones
        cfg_write(8'h00, 2'd1);
        check(cfg_rdata_o == 8'h03, "R12 reserved", cfg_rdata_o, 8'h03);
        check(level_o == 2'd0, "R3 all zero", level_o, 0);

        // R9: request concurrent with write uses old value
        cfg_we_i = 1'b1; cfg_wdata_i = 8'h7F; mode_i = 2'd0;
        req_valid_i = 1'b1; req_kind_i = 2'd0;
        @(negedge clk);
        cfg_we_i = 1'b0; req_valid_i = 1'b0;
        check(rsp_grant_o == 1'b1, "R9 old value", rsp_grant_o, 1);
        check(level_o == 2'd1, "R2 after write", level_o, 1);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule